// File: doc/BRIEF.md
# Host Wake-Request Access Handshake

This block is the control/status register that lets a host bring a power-gated internal domain out of low power and hold it awake while it reaches internal resources. The host first sets an init bit to enable the domain, then sets an access-request bit to keep the domain from entering sleep. The block sequences the domain's power enable, waits a modelled power-up latency, and reports clock-ready, going-to-sleep and a power-save type field. It also drives a grant signal that is true only when internal accesses are safe.

An internal controller may ask the domain to sleep through a sleep-request input. When the host is not holding the domain awake, the block opens a going-to-sleep window of fixed length and then powers the domain down. The window is cancelled if the request is withdrawn or the host asks for access. A power-up acknowledge input from the modelled power domain gates the wake count, and losing it while the domain is ready is recorded as an error.

Top module: `wake_access_ctrl`

## Requirements
- R1: The register reads bit 0 clock-ready, bit 2 init-done, bit 3 access-request, bit 4 going-to-sleep, bits 26..24 power-save type, bit 27 RF-kill level, and 0 in every other bit; after reset it reads 0 apart from bit 27.
- R2: Clock-ready reads 0 while init-done is 0, and rises once the wake condition (init-done 1, power enable out, power acknowledge in) has been sampled at WAKE_LAT consecutive clock edges (default 8); a write setting init-done counts from the edge after the write.
- R3: While access-request is 1, a ready domain stays ready and going-to-sleep stays 0, whatever the sleep request does.
- R4: The access grant output is 1 exactly when clock-ready is 1 and going-to-sleep is 0.
- R5: Going-to-sleep asserts in the cycle after sleep request is seen with the domain ready and access-request 0; after SLEEP_DLY cycles (default 4) with those held, clock-ready and going-to-sleep fall, the power enable output falls and the type reads 001.
- R6: Dropping the sleep request or setting access-request during the going-to-sleep window clears going-to-sleep at once and keeps clock-ready at 1.
- R7: From sleep, releasing the sleep request or setting access-request raises the power enable and clock-ready returns after WAKE_LAT edges of the wake condition.
- R8: The type field reads 011 for a recorded error, else 001 while the domain sleeps, else 010 while the RF-kill input is 1, else 000.
- R9: Bit 27 follows the RF-kill input level in the same cycle.
- R10: A write clearing init-done makes clock-ready and the power enable read 0 from the next cycle, and clears a recorded error one cycle later.
- R11: Writes to bits other than 2 and 3 have no effect on the read value.
- R12: Losing the power acknowledge while the domain is ready drops clock-ready on the next edge and records an error (type 011) that persists, through any later wake, until init-done is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read value |
| sleep_req_i | input | 1 | Sleep request from the internal controller |
| pwr_ack_i | input | 1 | Power-up acknowledge from the power domain |
| rfkill_i | input | 1 | RF-kill switch level |
| dom_pwr_en_o | output | 1 | Power enable to the internal domain |
| access_grant_o | output | 1 | Internal access is safe |

## Verification
The hardest situation to reach is the recorded error staying sticky across a second wake: it needs the acknowledge to vanish while the domain is ready, then to come back so the domain counts up again, all without clearing init-done. The bench models the power domain as an acknowledge that follows the enable output, with a separate kill control that forces it low for one stretch, then re-reads the type field after the renewed wake and again after init-done is cleared. The abort of the going-to-sleep window is reached by withdrawing the request partway through the count, and separately by an access-request write inside the window.

// File: rtl/wac_pkg.sv
// Shared types and bit positions for the wake-request access handshake.
// Assumes a single 32-bit control register at the block edge.
package wac_pkg;
    localparam int READY_BIT = 0;
    localparam int INIT_BIT  = 2;
    localparam int ACC_BIT   = 3;
    localparam int GTS_BIT   = 4;
    localparam int TYPE_LSB  = 24;
    localparam int RFK_BIT   = 27;

    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,
        PS_WAKING = 3'd1,
        PS_READY  = 3'd2,
        PS_DOZE   = 3'd3,
        PS_ASLEEP = 3'd4
    } pwr_state_t;

    typedef enum logic [2:0] {
        TYPE_NONE  = 3'b000,
        TYPE_MAC   = 3'b001,
        TYPE_RADIO = 3'b010,
        TYPE_ERROR = 3'b011
    } ps_type_t;
endpackage

// File: rtl/wac_host_bits.sv
// Host-writable control bits: init-done and access-request.
// Assumes every other bit of a write is read-only and dropped here.
module wac_host_bits
    import wac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          init_q,
    output logic          acc_q
);
    // Capture the two writable bits on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            acc_q  <= 1'b0;
        end else if (wr_en) begin
            init_q <= wr_data[INIT_BIT];
            acc_q  <= wr_data[ACC_BIT];
        end
    end
endmodule

// File: rtl/wac_power_seq.sv
// Power sequencer: wake latency count, going-to-sleep window, sleep state
// and sticky acknowledge-loss error. Assumes WAKE_LAT and SLEEP_DLY >= 1.
module wac_power_seq
    import wac_pkg::*;
#(
    parameter int WAKE_LAT  = 8,
    parameter int SLEEP_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_q,
    input  logic acc_q,
    input  logic sleep_req_i,
    input  logic pwr_ack_i,
    output logic pwr_en_o,
    output logic ready_o,
    output logic gts_o,
    output logic asleep_o,
    output logic err_o
);
    localparam int MAXC = (WAKE_LAT > SLEEP_DLY) ? WAKE_LAT : SLEEP_DLY;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WL_LAST = CW'(WAKE_LAT - 1);
    localparam logic [CW-1:0] SD_LAST = CW'(SLEEP_DLY - 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    pwr_state_t    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          err_q, err_n;
    logic          hold_asleep;

    // Domain stays powered off while asleep and nothing asks it to wake.
    always_comb begin
        hold_asleep = (st_q == PS_ASLEEP) && sleep_req_i && !acc_q;
        pwr_en_o    = init_q && !hold_asleep;
        ready_o     = init_q && ((st_q == PS_READY) || (st_q == PS_DOZE));
        gts_o       = init_q && (st_q == PS_DOZE) && sleep_req_i && !acc_q;
        asleep_o    = init_q && (st_q == PS_ASLEEP);
        err_o       = err_q;
    end

    // Next-state, counter and error flag.
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        err_n = err_q;
        if (!init_q) begin
            st_n  = PS_OFF;
            cnt_n = '0;
            err_n = 1'b0;
        end else begin
            case (st_q)
                PS_OFF, PS_ASLEEP: begin
                    if (pwr_en_o && pwr_ack_i) begin
                        if (WL_LAST == '0) begin
                            st_n  = PS_READY;
                            cnt_n = '0;
                        end else begin
                            st_n  = PS_WAKING;
                            cnt_n = ONE;
                        end
                    end else begin
                        cnt_n = '0;
                    end
                end
                PS_WAKING: begin
                    if (!pwr_ack_i) begin
                        st_n  = PS_OFF;
                        cnt_n = '0;
                    end else if (cnt_q == WL_LAST) begin
                        st_n  = PS_READY;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                PS_READY: begin
                    if (!pwr_ack_i) begin
                        st_n  = PS_OFF;
                        err_n = 1'b1;
                    end else if (sleep_req_i && !acc_q) begin
                        st_n  = PS_DOZE;
                        cnt_n = '0;
                    end
                end
                PS_DOZE: begin
                    if (!pwr_ack_i) begin
                        st_n  = PS_OFF;
                        cnt_n = '0;
                        err_n = 1'b1;
                    end else if (!sleep_req_i || acc_q) begin
                        st_n  = PS_READY;
                        cnt_n = '0;
                    end else if (cnt_q == SD_LAST) begin
                        st_n  = PS_ASLEEP;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                default: begin
                    st_n  = PS_OFF;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_OFF;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            err_q <= err_n;
        end
    end
endmodule

// File: rtl/wac_status_pack.sv
// Assembles the register read value and the access grant.
// Assumes inputs are already qualified by init-done where needed.
module wac_status_pack
    import wac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          init_q,
    input  logic          acc_q,
    input  logic          ready,
    input  logic          gts,
    input  logic          asleep,
    input  logic          err,
    input  logic          rfkill_i,
    output logic [DW-1:0] rd_data,
    output logic          grant
);
    ps_type_t ptype;

    // Power-save type by priority: error, sleep, radio kill, none.
    always_comb begin
        if (err)           ptype = TYPE_ERROR;
        else if (asleep)   ptype = TYPE_MAC;
        else if (rfkill_i) ptype = TYPE_RADIO;
        else               ptype = TYPE_NONE;
    end

    // Pack fields into their bit positions; unused bits read 0.
    always_comb begin
        rd_data                     = '0;
        rd_data[READY_BIT]          = ready;
        rd_data[INIT_BIT]           = init_q;
        rd_data[ACC_BIT]            = acc_q;
        rd_data[GTS_BIT]            = gts;
        rd_data[TYPE_LSB+2:TYPE_LSB] = ptype;
        rd_data[RFK_BIT]            = rfkill_i;
        grant                       = ready && !gts;
    end
endmodule

// File: rtl/wake_access_ctrl.sv
// Top of the host wake-request access handshake. Connects the host bits,
// the power sequencer and the read packer. Assumes one register, no address.
module wake_access_ctrl #(
    parameter int WAKE_LAT  = 8,
    parameter int SLEEP_DLY = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        sleep_req_i,
    input  logic        pwr_ack_i,
    input  logic        rfkill_i,
    output logic        dom_pwr_en_o,
    output logic        access_grant_o
);
    localparam int DW = 32;

    logic init_q, acc_q, ready, gts, asleep, err;

    wac_host_bits #(.DW(DW)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .init_q  (init_q),
        .acc_q   (acc_q)
    );

    wac_power_seq #(.WAKE_LAT(WAKE_LAT), .SLEEP_DLY(SLEEP_DLY)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_q      (init_q),
        .acc_q       (acc_q),
        .sleep_req_i (sleep_req_i),
        .pwr_ack_i   (pwr_ack_i),
        .pwr_en_o    (dom_pwr_en_o),
        .ready_o     (ready),
        .gts_o       (gts),
        .asleep_o    (asleep),
        .err_o       (err)
    );

    wac_status_pack #(.DW(DW)) u_pack (
        .init_q   (init_q),
        .acc_q    (acc_q),
        .ready    (ready),
        .gts      (gts),
        .asleep   (asleep),
        .err      (err),
        .rfkill_i (rfkill_i),
        .rd_data  (reg_rd_data),
        .grant    (access_grant_o)
    );
endmodule

// File: rtl/wake_access_ctrl_chk.sv
// Property checker for wake_access_ctrl, attached by bind below.
// Observes ports only.
module wake_access_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic        pwr_ack_i,
    input logic        rfkill_i,
    input logic        access_grant_o
);
    assert_ready_needs_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[2] |-> !reg_rd_data[0]);

    assert_hold_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[3] && reg_rd_data[0] && pwr_ack_i && !(reg_wr_en && !reg_wr_data[2]))
        |=> reg_rd_data[0]);

    assert_grant_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        access_grant_o |-> (reg_rd_data[0] && !reg_rd_data[4]));

    assert_gts_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[4] |-> (!reg_rd_data[3] && reg_rd_data[0]));

    assert_type_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[26]);

    assert_rfkill_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[27] == rfkill_i);

    assert_ack_loss_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[0] && !pwr_ack_i) |=> (reg_rd_data[26:24] == 3'b011));
endmodule

bind wake_access_ctrl wake_access_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_data    (reg_wr_data),
    .reg_rd_data    (reg_rd_data),
    .pwr_ack_i      (pwr_ack_i),
    .rfkill_i       (rfkill_i),
    .access_grant_o (access_grant_o)
);

// File: tb/wake_access_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module wake_access_ctrl_bench;
    localparam int WL = 8;
    localparam int SD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        sleep_req_i = 1'b0;
    logic        rfkill_i = 1'b0;
    logic        ack_kill = 1'b0;
    logic        pwr_ack_i;
    logic        dom_pwr_en_o;
    logic        access_grant_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Power domain model: acknowledge follows the enable unless killed.
    assign pwr_ack_i = dom_pwr_en_o && !ack_kill;

    always #10 clk = ~clk;

    wake_access_ctrl #(.WAKE_LAT(WL), .SLEEP_DLY(SD)) u_wake_access_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_en      (reg_wr_en),
        .reg_wr_data    (reg_wr_data),
        .reg_rd_data    (reg_rd_data),
        .sleep_req_i    (sleep_req_i),
        .pwr_ack_i      (pwr_ack_i),
        .rfkill_i       (rfkill_i),
        .dom_pwr_en_o   (dom_pwr_en_o),
        .access_grant_o (access_grant_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bring the domain to ready with init only, from off.
    task automatic bring_up(input logic [31:0] v);
        wr(v);
        edges(WL);
    endtask

    task automatic t_reset;
        chk_eq("R1 reset read", reg_rd_data, 32'h0);
        chk_eq("R1 reset pwr_en", {31'd0, dom_pwr_en_o}, 32'd0);
        chk_eq("R4 reset grant", {31'd0, access_grant_o}, 32'd0);
    endtask

    task automatic t_init_wake;
        edges(3);
        chk_eq("R2 no init no ready", reg_rd_data, 32'h0);
        wr(32'h4);
        edges(WL - 1);
        chk_eq("R2 ready before latency", reg_rd_data, 32'h4);
        edges(1);
        chk_eq("R2 ready at latency", reg_rd_data, 32'h5);
        chk_eq("R4 grant when ready", {31'd0, access_grant_o}, 32'd1);
    endtask

    task automatic t_doze_sleep;
        @(negedge clk);
        sleep_req_i = 1'b1;
        edges(1);
        chk_eq("R5 gts asserted", reg_rd_data, 32'h15);
        chk_eq("R4 no grant in window", {31'd0, access_grant_o}, 32'd0);
        edges(SD - 1);
        chk_eq("R5 gts still in window", reg_rd_data, 32'h15);
        edges(1);
        chk_eq("R5 asleep read", reg_rd_data, 32'h0100_0004);
        chk_eq("R5 pwr_en off asleep", {31'd0, dom_pwr_en_o}, 32'd0);
    endtask

    task automatic t_wake_release;
        @(negedge clk);
        sleep_req_i = 1'b0;
        #1;
        chk_eq("R7 pwr_en on release", {31'd0, dom_pwr_en_o}, 32'd1);
        edges(WL - 1);
        chk_eq("R7 not ready early", {31'd0, reg_rd_data[0]}, 32'd0);
        edges(1);
        chk_eq("R7 ready after release", reg_rd_data, 32'h5);
    endtask

    task automatic t_abort;
        @(negedge clk);
        sleep_req_i = 1'b1;
        edges(2);
        chk_eq("R6 in window", {31'd0, reg_rd_data[4]}, 32'd1);
        sleep_req_i = 1'b0;
        #1;
        chk_eq("R6 gts cleared at once", {31'd0, reg_rd_data[4]}, 32'd0);
        edges(SD + 2);
        chk_eq("R6 still ready after withdraw", reg_rd_data, 32'h5);
        @(negedge clk);
        sleep_req_i = 1'b1;
        edges(2);
        wr(32'hC);
        chk_eq("R6 access write cancels window", reg_rd_data, 32'hD);
    endtask

    task automatic t_access_hold;
        // Still sleep-requested with access held; domain must stay up.
        edges(SD + 10);
        chk_eq("R3 held awake", reg_rd_data, 32'hD);
        chk_eq("R3 grant held", {31'd0, access_grant_o}, 32'd1);
        wr(32'h4);
        edges(1);
        chk_eq("R5 window after access drop", {31'd0, reg_rd_data[4]}, 32'd1);
        edges(SD);
        chk_eq("R5 asleep again", reg_rd_data[26:24], 32'd1);
        // Wake by access request while sleep request stays high.
        wr(32'hC);
        edges(WL - 1);
        chk_eq("R7 access wake not yet", {31'd0, reg_rd_data[0]}, 32'd0);
        edges(1);
        chk_eq("R7 access wake ready", reg_rd_data, 32'hD);
        @(negedge clk);
        sleep_req_i = 1'b0;
    endtask

    task automatic t_rfkill;
        @(negedge clk);
        rfkill_i = 1'b1;
        #1;
        chk_eq("R9 rfkill mirror", {31'd0, reg_rd_data[27]}, 32'd1);
        chk_eq("R8 radio type", reg_rd_data, 32'h0A00_000D);
        rfkill_i = 1'b0;
        #1;
        chk_eq("R9 rfkill low", reg_rd_data, 32'hD);
    endtask

    task automatic t_ack_loss;
        @(negedge clk);
        ack_kill = 1'b1;
        edges(1);
        chk_eq("R12 ready lost", {31'd0, reg_rd_data[0]}, 32'd0);
        chk_eq("R12 error type", reg_rd_data[26:24], 32'd3);
        ack_kill = 1'b0;
        edges(WL + 1);
        chk_eq("R12 rewoken ready", {31'd0, reg_rd_data[0]}, 32'd1);
        chk_eq("R8 error sticky over wake", reg_rd_data[26:24], 32'd3);
        wr(32'h0);
        chk_eq("R10 ready drops on init clear", {31'd0, reg_rd_data[0]}, 32'd0);
        chk_eq("R10 pwr_en drops on init clear", {31'd0, dom_pwr_en_o}, 32'd0);
        edges(1);
        chk_eq("R10 error cleared", reg_rd_data, 32'h0);
    endtask

    task automatic t_ro_writes;
        wr(32'hFFFF_FFFF);
        chk_eq("R11 ro bits ignored", reg_rd_data, 32'hC);
        wr(32'hFFFF_FFF3);
        chk_eq("R11 clear via rw bits only", reg_rd_data, 32'h0);
        edges(WL + 2);
        chk_eq("R2 stays off without init", reg_rd_data, 32'h0);
        bring_up(32'h4);
        chk_eq("R1 ready read value", reg_rd_data, 32'h5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_init_wake();
        t_doze_sleep();
        t_wake_release();
        t_abort();
        t_access_hold();
        t_rfkill();
        t_ack_loss();
        t_ro_writes();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule